// File: doc/BRIEF.md
# Half-Duplex Differential Bus UART with Echo Self-Test

This block is a byte-oriented asynchronous serial transmitter and receiver meant to sit in front of a half-duplex differential line transceiver. A single internal direction level, held in registers, produces both the transceiver's driver enable (active high) and receiver enable (active low). The direction is raised when a byte is taken for sending, stays raised across bytes queued back to back, and is dropped one bit time after the last stop bit. While the driver is on, incoming data from the line is ignored.

With self-test enabled, the receiver is kept listening during transmission, so each sent byte comes back through the transceiver as an echo. The block compares every echo with the byte it sent. A wrong value, a framing error on the echo, or an echo that does not arrive within one frame time after the stop bit sets a sticky fault flag. This lets wiring breaks, shorts and dead transceivers be found in the field. A dedicated input clears the flag.

Bit timing comes from a clock divisor parameter. The receiver works at sixteen samples per bit. Framing above the byte level is left to the surrounding logic.

Top module: `rs485_uart_echo`

## Requirements
- R1: `de` is 1 from the cycle after a byte is accepted until the direction drops. When self-test is off, `re_n` equals `de`. When the block is idle, `de`=0 and `re_n`=0.
- R2: A frame on `txd` is one start bit (0), eight data bits least significant first, and one stop bit (1). Each bit lasts 16*CLK_DIV clocks. `txd` is 1 whenever `de` is 0.
- R3: `tx_ready` is 1 when the block is idle or in the post-frame hold bit, and 0 in the middle of a frame. In the cycle after `tx_valid && tx_ready`, `de`=1 and `txd`=0.
- R4: After the stop bit ends, `de` stays 1 for one more bit time and then drops to 0. A byte accepted during that hold bit starts a new frame with no cycle of `de`=0.
- R5: The receiver samples `rxd` at the middle of each bit and gives a received byte as a one-cycle `rx_valid` pulse with `rx_data`.
- R6: A low pulse on `rxd` that has ended before the middle of the start bit produces no `rx_valid`.
- R7: `rx_frame_err` is 1 with `rx_valid` when the sampled stop bit is 0, and 0 when it is 1.
- R8: When self-test is off, a frame arriving on `rxd` while `de`=1 produces no `rx_valid`. Reception works again once the driver has been released.
- R9: When self-test is on, `re_n` is 0 at all times. An echoed byte that differs from the byte sent sets `echo_fault`.
- R10: When self-test is on and no echo arrives, `echo_fault` is set exactly (DATA_W+2)*16*CLK_DIV clocks after the end of the stop bit. A correct echo never sets it.
- R11: `echo_fault` stays set until `fault_clr` is high at a clock edge. If a new fault occurs in the same cycle as a clear, the fault wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| rx_data | output | DATA_W | Received byte |
| rx_valid | output | 1 | One-cycle pulse, received byte valid |
| rx_frame_err | output | 1 | Stop bit of the received byte was low |
| selftest_en | input | 1 | Keep receiver listening and check echoes |
| fault_clr | input | 1 | Clears the echo fault flag |
| echo_fault | output | 1 | Sticky echo mismatch or missing-echo flag |
| txd | output | 1 | Serial data to transceiver driver input |
| rxd | input | 1 | Serial data from transceiver receiver output |
| de | output | 1 | Driver enable, active high |
| re_n | output | 1 | Receiver enable, active low |

## Verification
The fault flag's set path and its clear input can act in the same cycle, and the result must be that the flag stays set. The bench creates this case by holding `fault_clr` high for a whole self-test frame whose echo is corrupted on purpose. A line override forces `rxd` high once the start bit has been checked, so the echo is read back as all ones. When the mismatch is detected, the flag must rise for at least one cycle while the clear is still active, and it must read zero after the clear is released. A design in which the clear wins never shows that pulse, and the bench's check on it fails.

// File: rtl/rs485_pkg.sv
package rs485_pkg;
  localparam int OVS = 16;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_STOP,
    TX_HOLD
  } tx_state_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/rs485_tx.sv
module rs485_tx
  import rs485_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              selftest_en,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              txd,
  output logic              de,
  output logic              re_n,
  output logic              start_o,
  output logic              done_o
);
  localparam int BIT_CLKS = OVS * CLK_DIV;
  localparam int CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  tx_state_e         state, nxt;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bidx;
  logic [DATA_W-1:0] sh;
  logic              txd_q, de_q, ren_q;
  logic              bit_end, last_bit, accept, dir_d;

  assign bit_end  = (cnt == CW'(BIT_CLKS - 1));
  assign last_bit = (bidx == BW'(DATA_W - 1));
  assign in_ready = (state == TX_IDLE) || (state == TX_HOLD);
  assign accept   = in_valid && in_ready;
  assign start_o  = accept;
  assign done_o   = (state == TX_STOP) && bit_end;

  always_comb begin
    nxt = state;
    case (state)
      TX_IDLE:  if (accept) nxt = TX_START;
      TX_START: if (bit_end) nxt = TX_DATA;
      TX_DATA:  if (bit_end && last_bit) nxt = TX_STOP;
      TX_STOP:  if (bit_end) nxt = TX_HOLD;
      TX_HOLD: begin
        if (accept) nxt = TX_START;
        else if (bit_end) nxt = TX_IDLE;
      end
      default:  nxt = TX_IDLE;
    endcase
    dir_d = (nxt != TX_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TX_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      sh    <= '0;
      txd_q <= 1'b1;
      de_q  <= 1'b0;
      ren_q <= 1'b0;
    end else begin
      state <= nxt;
      de_q  <= dir_d;
      ren_q <= dir_d & ~selftest_en;
      if (accept) begin
        sh    <= in_data;
        cnt   <= '0;
        bidx  <= '0;
        txd_q <= 1'b0;
      end else if (state != TX_IDLE) begin
        cnt <= bit_end ? '0 : cnt + 1'b1;
        if (bit_end) begin
          case (state)
            TX_START: begin
              txd_q <= sh[0];
              sh    <= {1'b1, sh[DATA_W-1:1]};
            end
            TX_DATA: begin
              txd_q <= last_bit ? 1'b1 : sh[0];
              sh    <= {1'b1, sh[DATA_W-1:1]};
              bidx  <= bidx + 1'b1;
            end
            default: txd_q <= 1'b1;
          endcase
        end
      end
    end
  end

  assign txd  = txd_q;
  assign de   = de_q;
  assign re_n = ren_q;

  assert_mark_when_released_R2: assert property (@(posedge clk) disable iff (rst)
    !de |-> txd);
  assert_accept_starts_frame_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (de && !txd));
endmodule

// File: rtl/rs485_rx.sv
module rs485_rx
  import rs485_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              rxd,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_ferr
);
  localparam int DW  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int OW  = $clog2(OVS);
  localparam int BW  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int MID = OVS / 2;

  rx_state_e         state;
  logic              s1, s2;
  logic [DW-1:0]     dcnt;
  logic              tick;
  logic [OW-1:0]     ocnt;
  logic [BW-1:0]     bidx;
  logic [DATA_W-1:0] sh;

  assign tick = (dcnt == DW'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      dcnt <= '0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      dcnt <= tick ? '0 : dcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      ocnt      <= '0;
      bidx      <= '0;
      sh        <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_ferr  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (!rx_en) begin
        state <= RX_IDLE;
      end else if (tick) begin
        case (state)
          RX_IDLE: if (!s2) begin
            state <= RX_START;
            ocnt  <= '0;
          end
          RX_START: begin
            if (ocnt == OW'(MID - 1)) begin
              ocnt <= '0;
              bidx <= '0;
              state <= s2 ? RX_IDLE : RX_DATA;
            end else ocnt <= ocnt + 1'b1;
          end
          RX_DATA: begin
            if (ocnt == OW'(OVS - 1)) begin
              ocnt <= '0;
              sh   <= {s2, sh[DATA_W-1:1]};
              if (bidx == BW'(DATA_W - 1)) state <= RX_STOP;
              else bidx <= bidx + 1'b1;
            end else ocnt <= ocnt + 1'b1;
          end
          RX_STOP: begin
            if (ocnt == OW'(OVS - 1)) begin
              out_valid <= 1'b1;
              out_data  <= sh;
              out_ferr  <= !s2;
              state     <= RX_IDLE;
            end else ocnt <= ocnt + 1'b1;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assert_valid_single_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
endmodule

// File: rtl/rs485_echo_chk.sv
module rs485_echo_chk
  import rs485_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              selftest_en,
  input  logic              tx_start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_done,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_ferr,
  input  logic              clr,
  output logic              fault
);
  localparam int FRAME_CLKS = (DATA_W + 2) * OVS * CLK_DIV;
  localparam int TW = $clog2(FRAME_CLKS);

  logic [DATA_W-1:0] expect_q;
  logic              pend, run, fault_q;
  logic [TW-1:0]     tcnt;
  logic              hit, mism, expire, overrun, set_f;

  assign hit     = pend && rx_valid;
  assign mism    = hit && ((rx_data != expect_q) || rx_ferr);
  assign expire  = run && (tcnt == TW'(FRAME_CLKS - 1));
  assign overrun = tx_start && pend && selftest_en;
  assign set_f   = mism || expire || overrun;

  always_ff @(posedge clk) begin
    if (rst) begin
      expect_q <= '0;
      pend     <= 1'b0;
      run      <= 1'b0;
      tcnt     <= '0;
      fault_q  <= 1'b0;
    end else begin
      if (tx_start) begin
        expect_q <= tx_byte;
        pend     <= selftest_en;
        run      <= 1'b0;
      end else if (hit || expire) begin
        pend <= 1'b0;
        run  <= 1'b0;
      end else if (tx_done && pend) begin
        run  <= 1'b1;
        tcnt <= '0;
      end else if (run) begin
        tcnt <= tcnt + 1'b1;
      end

      if (set_f) fault_q <= 1'b1;
      else if (clr) fault_q <= 1'b0;
    end
  end

  assign fault = fault_q;

  assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(fault) && !$past(clr)) |-> fault);
  assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (rst)
    set_f |=> fault);
endmodule

// File: rtl/rs485_uart_echo.sv
module rs485_uart_echo #(
  parameter int CLK_DIV = 2,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_frame_err,
  input  logic              selftest_en,
  input  logic              fault_clr,
  output logic              echo_fault,
  output logic              txd,
  input  logic              rxd,
  output logic              de,
  output logic              re_n
);
  logic tx_start, tx_done;

  rs485_tx #(.CLK_DIV(CLK_DIV), .DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .selftest_en(selftest_en),
    .in_data(tx_data), .in_valid(tx_valid), .in_ready(tx_ready),
    .txd(txd), .de(de), .re_n(re_n),
    .start_o(tx_start), .done_o(tx_done)
  );

  rs485_rx #(.CLK_DIV(CLK_DIV), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .rx_en(!re_n), .rxd(rxd),
    .out_data(rx_data), .out_valid(rx_valid), .out_ferr(rx_frame_err)
  );

  rs485_echo_chk #(.CLK_DIV(CLK_DIV), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .selftest_en(selftest_en),
    .tx_start(tx_start), .tx_byte(tx_data), .tx_done(tx_done),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ferr(rx_frame_err),
    .clr(fault_clr), .fault(echo_fault)
  );

  assert_no_rx_while_driving_R8: assert property (@(posedge clk) disable iff (rst)
    (de && $past(de) && !$past(selftest_en, 2)) |-> !rx_valid);
  assert_selftest_listens_R9: assert property (@(posedge clk) disable iff (rst)
    $past(selftest_en) |-> !re_n);
endmodule

// File: tb/sim_rs485_uart_echo.sv
`timescale 1ns/1ps
module sim_rs485_uart_echo;
  localparam int DIV = 2;
  localparam int B   = 16 * DIV;
  localparam int HB  = B / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid, rx_frame_err;
  logic       selftest_en = 1'b0;
  logic       fault_clr = 1'b0;
  logic       echo_fault, txd, de, re_n;
  logic       lb = 1'b0, force_hi = 1'b0, bench_rxd = 1'b1;
  logic       rxd;

  int checks = 0, fails = 0;
  int got = 0;
  logic [7:0] got_data;
  logic       got_err;
  int de_low = 0;
  logic watch_de = 1'b0;
  int clr_pulse = 0;

  assign rxd = lb ? (txd | force_hi) : bench_rxd;

  always #2 clk = ~clk;

  rs485_uart_echo #(.CLK_DIV(DIV), .DATA_W(8)) u0 (
    .clk(clk), .rst(rst), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
    .selftest_en(selftest_en), .fault_clr(fault_clr), .echo_fault(echo_fault),
    .txd(txd), .rxd(rxd), .de(de), .re_n(re_n)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      got = got + 1;
      got_data = rx_data;
      got_err = rx_frame_err;
    end
    if (watch_de && !de) de_low = de_low + 1;
    if (echo_fault && fault_clr) clr_pulse = clr_pulse + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    tx_data = b;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // Called at the negedge right after acceptance; samples mid-bit.
  task automatic check_frame(input logic [7:0] b, input logic st);
    int pos = 0;
    for (int i = 0; i < 10; i++) begin
      repeat (i * B + HB - pos) @(negedge clk);
      pos = i * B + HB;
      chk("R2 frame bit", int'(txd), (i == 0) ? 0 : (i == 9) ? 1 : int'(b[i-1]));
      chk("R1 de while sending", int'(de), 1);
      chk("R1 re_n while sending", int'(re_n), st ? 0 : 1);
      if (i == 4) chk("R3 ready low mid-frame", int'(tx_ready), 0);
    end
  endtask

  task automatic drive_rx(input logic [7:0] b, input logic stop_low);
    @(negedge clk);
    bench_rxd = 1'b0;
    repeat (B) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      bench_rxd = b[i];
      repeat (B) @(negedge clk);
    end
    if (stop_low) begin
      bench_rxd = 1'b0;
      repeat (HB + 4) @(negedge clk);
      bench_rxd = 1'b1;
      repeat (B - HB - 4) @(negedge clk);
    end else begin
      bench_rxd = 1'b1;
      repeat (B) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R3 reset ready", int'(tx_ready), 1);
    chk("R1 reset de", int'(de), 0);
    chk("R1 reset re_n", int'(re_n), 0);
    chk("R2 reset txd mark", int'(txd), 1);
    chk("R11 reset fault", int'(echo_fault), 0);
    chk("R5 reset valid", int'(rx_valid), 0);
  endtask

  task automatic t_tx_frame();
    send_byte(8'hA5);
    check_frame(8'hA5, 1'b0);
    repeat (B) @(negedge clk);
    chk("R4 hold bit de", int'(de), 1);
    chk("R3 ready in hold", int'(tx_ready), 1);
    chk("R2 mark in hold", int'(txd), 1);
    repeat (B) @(negedge clk);
    chk("R4 released de", int'(de), 0);
    chk("R1 idle re_n", int'(re_n), 0);
  endtask

  task automatic t_back2back();
    send_byte(8'h55);
    watch_de = 1'b1;
    de_low = 0;
    send_byte(8'hAA);
    check_frame(8'hAA, 1'b0);
    watch_de = 1'b0;
    chk("R4 no de gap between bytes", de_low, 0);
    repeat (3 * B) @(negedge clk);
  endtask

  task automatic t_rx_byte();
    got = 0;
    drive_rx(8'hC3, 1'b0);
    repeat (B) @(negedge clk);
    chk("R5 rx count", got, 1);
    chk("R5 rx data", int'(got_data), 8'hC3);
    chk("R7 no frame err", int'(got_err), 0);
  endtask

  task automatic t_rx_ferr();
    got = 0;
    drive_rx(8'h3C, 1'b1);
    repeat (2 * B) @(negedge clk);
    chk("R7 ferr count", got, 1);
    chk("R7 ferr data", int'(got_data), 8'h3C);
    chk("R7 ferr flag", int'(got_err), 1);
  endtask

  task automatic t_glitch();
    got = 0;
    @(negedge clk);
    bench_rxd = 1'b0;
    repeat (4) @(negedge clk);
    bench_rxd = 1'b1;
    repeat (12 * B) @(negedge clk);
    chk("R6 glitch rejected", got, 0);
  endtask

  task automatic t_gate();
    got = 0;
    send_byte(8'h11);
    drive_rx(8'h5A, 1'b0);
    repeat (3 * B) @(negedge clk);
    chk("R8 no rx while driving", got, 0);
    drive_rx(8'h66, 1'b0);
    repeat (B) @(negedge clk);
    chk("R8 rx after release", got, 1);
    chk("R8 rx data after release", int'(got_data), 8'h66);
  endtask

  task automatic t_echo_ok();
    got = 0;
    send_byte(8'hA5);
    repeat (HB) @(negedge clk);
    chk("R9 re_n low in self-test", int'(re_n), 0);
    chk("R1 de in self-test", int'(de), 1);
    repeat (10 * B) @(negedge clk);
    chk("R9 echo received", got, 1);
    chk("R9 echo data", int'(got_data), 8'hA5);
    chk("R9 good echo no fault", int'(echo_fault), 0);
    repeat (12 * B) @(negedge clk);
    chk("R10 no false timeout", int'(echo_fault), 0);
  endtask

  task automatic t_echo_bad();
    send_byte(8'h3C);
    repeat (B + 4) @(negedge clk);
    force_hi = 1'b1;
    repeat (11 * B) @(negedge clk);
    force_hi = 1'b0;
    chk("R9 mismatch fault", int'(echo_fault), 1);
    repeat (3 * B) @(negedge clk);
    chk("R11 fault sticky", int'(echo_fault), 1);
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    chk("R11 fault cleared", int'(echo_fault), 0);
  endtask

  task automatic t_echo_missing();
    lb = 1'b0;
    bench_rxd = 1'b1;
    send_byte(8'h5A);
    repeat (20 * B - 8) @(negedge clk);
    chk("R10 not yet timed out", int'(echo_fault), 0);
    repeat (16) @(negedge clk);
    chk("R10 missing echo fault", int'(echo_fault), 1);
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    lb = 1'b1;
    repeat (B) @(negedge clk);
  endtask

  task automatic t_clr_collide();
    clr_pulse = 0;
    fault_clr = 1'b1;
    send_byte(8'h3C);
    repeat (B + 4) @(negedge clk);
    force_hi = 1'b1;
    repeat (11 * B) @(negedge clk);
    force_hi = 1'b0;
    chk("R11 set wins over clear", int'(clr_pulse > 0), 1);
    fault_clr = 1'b0;
    @(negedge clk);
    chk("R11 cleared after collision", int'(echo_fault), 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_tx_frame();
    repeat (2 * B) @(negedge clk);
    t_back2back();
    t_rx_byte();
    t_rx_ferr();
    t_glitch();
    t_gate();
    repeat (3 * B) @(negedge clk);
    selftest_en = 1'b1;
    lb = 1'b1;
    repeat (2) @(negedge clk);
    t_echo_ok();
    t_echo_bad();
    repeat (2 * B) @(negedge clk);
    t_echo_missing();
    t_clr_collide();
    repeat (2 * B) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule